// File: doc/BRIEF.md
# AC-link Output Frame Serializer

This block assembles outgoing AC-link frames and shifts them onto one serial data line, one bit per bit clock, together with the frame sync. A frame opens with a 16-bit tag slot. Twelve 20-bit data slots follow it, numbered 1 to 12. Slot 1 holds the command address and slot 2 the command data. Slots 3 and 4 hold front left and front right PCM. Slot 5 is line-1 DAC and slot 6 is centre. Slots 7 and 8 are surround left and right. Slot 9 is LFE, slot 10 is line-2 DAC and slot 11 is handset DAC. Slot 12 is GPIO control.

Two transmit channels, A and B, each queue 20-bit words in a small FIFO inside the block. A slot routing table assigns each data slot to channel A, to channel B or to no channel. At the first bit of each frame the block latches the routing table and the queue levels. It then marks in the tag which slots will carry a fresh word. Each flagged slot takes the next word of its channel at the moment that slot starts. A slot without data goes out as zeros, with its tag bit cleared.

Top module: `ac_out_serializer`

## Requirements
- R1: While rst_ni is low, sync_o, sdata_o, a_full_o and b_full_o are all low.
- R2: While enable_i stays high, frames follow each other without gaps. Each frame is 256 bit clocks long. sync_o is high for the 16 bit clocks of the tag slot and low for the other 240.
- R3: The tag slot is sent MSB first. Bit 15 is set when at least one data slot in the frame is valid. Bit 14-k flags data slot k+1, for k from 0 to 11. Bits 2..0 are zero.
- R4: Each data slot carries 20 bits, MSB first. A valid slot carries the next queued word of its channel. An invalid slot carries all zeros.
- R5: assign_i[2k+1:2k] routes data slot k+1. Code 01 selects channel A and code 10 selects channel B. Codes 00 and 11 leave the slot empty.
- R6: The routing table and both queue levels are sampled at the first bit of a frame. Take n as the number of words a channel holds at that point. The channel's first n routed slots, in ascending slot order, are valid. Changes to assign_i during a frame take effect at the next frame.
- R7: While enable_i is low at a rising edge, sync_o and sdata_o are low after that edge and the frame position is cleared. At the first edge where enable_i is high again, a new frame begins with tag bit 15.
- R8: Each channel FIFO holds 16 words. The full output is high when the FIFO holds 16 words. A push while full is dropped, and the queued words keep their order.
- R9: A word leaves its FIFO only at the start of the slot that carries it. A word pushed after a frame has started cannot be sent before the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock, outputs change on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Global frame enable |
| assign_i | input | 24 | Slot routing table, 2 bits per data slot |
| a_push_i | input | 1 | Push a word into channel A |
| a_data_i | input | 20 | Channel A word |
| a_full_o | output | 1 | Channel A FIFO full |
| b_push_i | input | 1 | Push a word into channel B |
| b_data_i | input | 20 | Channel B word |
| b_full_o | output | 1 | Channel B FIFO full |
| sync_o | output | 1 | Frame sync, high during the tag slot |
| sdata_o | output | 1 | Serial frame data |

## Verification
The hardest case to reach is a frame in which one channel feeds more slots than it holds words, so some routed slots are valid and later ones are not. The bench creates it by filling channel A past capacity while enable_i is low, routing all twelve slots to A and then enabling. Two frames run back to back and leave the queue part-empty, with pushes still arriving. The bench also rewrites the routing table in the middle of a frame and removes enable_i in the middle of a frame. A behavioural queue model then confirms that neither change disturbs words already committed.

// File: rtl/ac_out_pkg.sv
package ac_out_pkg;
  typedef enum logic [1:0] {
    SEL_NONE  = 2'b00,
    SEL_A     = 2'b01,
    SEL_B     = 2'b10,
    SEL_NONE2 = 2'b11
  } slot_sel_e;
endpackage

// File: rtl/ac_word_fifo.sv
module ac_word_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && (cnt_q != '0);
  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= ptr_inc(wr_q);
      if (do_pop)  rd_q <= ptr_inc(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  a_r9_pop_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0);
  a_r8_full_push_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> full_o);
endmodule

// File: rtl/ac_tag_build.sv
module ac_tag_build
  import ac_out_pkg::*;
#(
  parameter int NUM_SLOTS = 12,
  parameter int CW        = 5
) (
  input  logic [2*NUM_SLOTS-1:0] sel_i,
  input  logic [CW-1:0]          cnt_a_i,
  input  logic [CW-1:0]          cnt_b_i,
  output logic [NUM_SLOTS-1:0]   valid_o
);
  int used_a, used_b;

  // channel slots are granted in ascending order while words remain
  always_comb begin
    used_a  = 0;
    used_b  = 0;
    valid_o = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (sel_i[2*k +: 2] == SEL_A) begin
        valid_o[k] = int'(cnt_a_i) > used_a;
        used_a++;
      end else if (sel_i[2*k +: 2] == SEL_B) begin
        valid_o[k] = int'(cnt_b_i) > used_b;
        used_b++;
      end
    end
  end
endmodule

// File: rtl/ac_out_serializer.sv
module ac_out_serializer
  import ac_out_pkg::*;
#(
  parameter int SLOT_W     = 20,
  parameter int TAG_W      = 16,
  parameter int NUM_SLOTS  = 12,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   enable_i,
  input  logic [2*NUM_SLOTS-1:0] assign_i,
  input  logic                   a_push_i,
  input  logic [SLOT_W-1:0]      a_data_i,
  output logic                   a_full_o,
  input  logic                   b_push_i,
  input  logic [SLOT_W-1:0]      b_data_i,
  output logic                   b_full_o,
  output logic                   sync_o,
  output logic                   sdata_o
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int SW = $clog2(NUM_SLOTS + 1);
  localparam int BW = $clog2(SLOT_W);

  logic              push [2];
  logic [SLOT_W-1:0] din  [2];
  logic [SLOT_W-1:0] head [2];
  logic [CW-1:0]     cnt  [2];
  logic              full [2];
  logic [1:0]        pop;

  assign push[0] = a_push_i;
  assign push[1] = b_push_i;
  assign din[0]  = a_data_i;
  assign din[1]  = b_data_i;
  assign a_full_o = full[0];
  assign b_full_o = full[1];

  for (genvar c = 0; c < 2; c++) begin : g_chan
    ac_word_fifo #(.W(SLOT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (push[c]),
      .data_i (din[c]),
      .pop_i  (pop[c]),
      .data_o (head[c]),
      .count_o(cnt[c]),
      .full_o (full[c])
    );
  end

  logic [NUM_SLOTS-1:0] valid_new;

  ac_tag_build #(.NUM_SLOTS(NUM_SLOTS), .CW(CW)) u_tag (
    .sel_i  (assign_i),
    .cnt_a_i(cnt[0]),
    .cnt_b_i(cnt[1]),
    .valid_o(valid_new)
  );

  logic                   active_q, sync_q, sd_q;
  logic [SW-1:0]          slot_q, slot_d, slot_idx;
  logic [BW-1:0]          bit_q, bit_d;
  logic [SLOT_W-1:0]      sr_q, load_word;
  logic [NUM_SLOTS-1:0]   valid_q;
  logic [2*NUM_SLOTS-1:0] asg_q;
  logic [TAG_W-1:0]       tag;
  logic                   last_bit, frame_start, slot_start;

  assign last_bit = (slot_q == '0) ? (bit_q == BW'(TAG_W - 1)) : (bit_q == BW'(SLOT_W - 1));

  always_comb begin
    if (!active_q) begin
      slot_d = '0;
      bit_d  = '0;
    end else if (last_bit) begin
      bit_d  = '0;
      slot_d = (slot_q == SW'(NUM_SLOTS)) ? '0 : slot_q + 1'b1;
    end else begin
      bit_d  = bit_q + 1'b1;
      slot_d = slot_q;
    end
  end

  assign frame_start = enable_i && (slot_d == '0) && (bit_d == '0);
  assign slot_start  = enable_i && (slot_d != '0) && (bit_d == '0);
  assign slot_idx    = slot_d - 1'b1;

  always_comb begin
    tag = '0;
    tag[TAG_W-1] = |valid_new;
    for (int k = 0; k < NUM_SLOTS; k++) tag[TAG_W-2-k] = valid_new[k];
  end

  always_comb begin
    pop       = '0;
    load_word = '0;
    if (frame_start) begin
      load_word = {tag, {(SLOT_W - TAG_W){1'b0}}};
    end else if (slot_start && valid_q[slot_idx]) begin
      if (asg_q[2*slot_idx +: 2] == SEL_A) begin
        pop[0]    = 1'b1;
        load_word = head[0];
      end else begin
        pop[1]    = 1'b1;
        load_word = head[1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sync_q   <= 1'b0;
      sd_q     <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
      sr_q     <= '0;
      valid_q  <= '0;
      asg_q    <= '0;
    end else if (!enable_i) begin
      active_q <= 1'b0;
      sync_q   <= 1'b0;
      sd_q     <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
    end else begin
      active_q <= 1'b1;
      slot_q   <= slot_d;
      bit_q    <= bit_d;
      sync_q   <= (slot_d == '0);
      if (frame_start) begin
        valid_q <= valid_new;
        asg_q   <= assign_i;
      end
      if (frame_start || slot_start) begin
        sd_q <= load_word[SLOT_W-1];
        sr_q <= load_word << 1;
      end else begin
        sd_q <= sr_q[SLOT_W-1];
        sr_q <= sr_q << 1;
      end
    end
  end

  assign sync_o  = sync_q;
  assign sdata_o = sd_q;

  a_r2_sync_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sync_o) && $past(enable_i)) |-> ($past(sync_o, 16) && !$past(sync_o, 17)));
  a_r7_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!sync_o && !sdata_o));
  a_r9_pop_in_data_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pop) |=> !sync_o);
  a_r4_one_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pop) <= 1);
endmodule

// File: tb/ac_out_serializer_bench.sv
module ac_out_serializer_bench;
  localparam int DEPTH = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic [23:0] assign_i = '0;
  logic        a_push_i = 1'b0, b_push_i = 1'b0;
  logic [19:0] a_data_i = '0, b_data_i = '0;
  logic        a_full_o, b_full_o, sync_o, sdata_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  ac_out_serializer u_ac_out_serializer (
    .clk_i, .rst_ni, .enable_i, .assign_i,
    .a_push_i, .a_data_i, .a_full_o,
    .b_push_i, .b_data_i, .b_full_o,
    .sync_o, .sdata_o
  );

  // behavioural reference
  bit [19:0] qa[$], qb[$];
  bit        m_act, m_sync, m_sd, acc_a, acc_b;
  int        m_pos, na, nb, k;
  bit [11:0] fv;
  bit [1:0]  fasg [12];
  bit [15:0] tagv;
  bit [19:0] cur;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      qa.delete(); qb.delete();
      m_act = 0; m_sync = 0; m_sd = 0; m_pos = 0;
    end else begin
      acc_a = a_push_i && qa.size() < DEPTH;
      acc_b = b_push_i && qb.size() < DEPTH;
      if (!enable_i) begin
        m_act = 0; m_sync = 0; m_sd = 0;
      end else begin
        if (!m_act) begin m_act = 1; m_pos = 0; end
        else m_pos = (m_pos + 1) % 256;
        if (m_pos == 0) begin
          na = 0; nb = 0; tagv = '0;
          for (int s = 0; s < 12; s++) begin
            fasg[s] = assign_i[2*s +: 2];
            fv[s] = 0;
            if (fasg[s] == 2'b01) begin fv[s] = qa.size() > na; na++; end
            if (fasg[s] == 2'b10) begin fv[s] = qb.size() > nb; nb++; end
            tagv[14-s] = fv[s];
          end
          tagv[15] = |fv;
          cur = {tagv, 4'b0};
        end else if (m_pos >= 16 && (m_pos - 16) % 20 == 0) begin
          k = (m_pos - 16) / 20;
          if (fv[k]) cur = (fasg[k] == 2'b01) ? qa.pop_front() : qb.pop_front();
          else cur = '0;
        end
        m_sync = m_pos < 16;
        m_sd = (m_pos < 16) ? cur[19 - m_pos] : cur[19 - ((m_pos - 16) % 20)];
      end
      if (acc_a) qa.push_back(a_data_i);
      if (acc_b) qb.push_back(b_data_i);
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pos=%0d actual=%b expected=%b at %0t", req, m_pos, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R2 sync", sync_o, m_sync);
      if (!m_act) chk("R7 idle data", sdata_o, m_sd);
      else if (m_pos < 16) chk("R3 tag bit", sdata_o, m_sd);
      else chk("R4/R5/R6/R9 slot bit", sdata_o, m_sd);
      chk("R8 full A", a_full_o, qa.size() == DEPTH);
      chk("R8 full B", b_full_o, qb.size() == DEPTH);
    end
  end

  task automatic push_a(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); a_push_i = 1; a_data_i = 20'(base + i * 20'h1357);
    end
    @(negedge clk_i); a_push_i = 0;
  endtask

  task automatic push_b(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); b_push_i = 1; b_data_i = 20'(base ^ (i * 20'h2af1));
    end
    @(negedge clk_i); b_push_i = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    wait_cyc(3);
    // R1 reset state
    chk("R1 sync", sync_o, 1'b0);
    chk("R1 sdata", sdata_o, 1'b0);
    chk("R1 fullA", a_full_o, 1'b0);
    chk("R1 fullB", b_full_o, 1'b0);
    rst_ni = 1;
    wait_cyc(5);
    // R5 stereo routing: slot3 -> A, slot4 -> B, slot 6 code 11 (none)
    assign_i = '0;
    assign_i[5:4] = 2'b01;
    assign_i[7:6] = 2'b10;
    assign_i[11:10] = 2'b11;
    push_a(3, 20'hA1234);
    push_b(2, 20'h5B0C7);
    enable_i = 1;
    fork
      wait_cyc(800);
      push_a(2, 20'h0F0F0);
    join
    // R6 change routing mid-frame
    wait_cyc(90);
    assign_i = 24'h0;
    for (int s = 0; s < 12; s++) assign_i[2*s +: 2] = (s % 3 == 0) ? 2'b01 : ((s % 3 == 1) ? 2'b10 : 2'b00);
    push_a(5, 20'hFEDCB);
    push_b(7, 20'h13579);
    wait_cyc(700);
    // R8 overfill while idle, then all slots to A (R6 partial grant)
    enable_i = 0;
    wait_cyc(4);
    push_a(20, 20'h80001);
    assign_i = 24'h555555;
    wait_cyc(2);
    enable_i = 1;
    fork
      wait_cyc(600);
      begin wait_cyc(300); push_a(6, 20'h3C3C3); end
    join
    // R7 disable mid-frame, re-enable
    wait_cyc(37);
    enable_i = 0;
    wait_cyc(9);
    push_b(4, 20'h7E7E7);
    assign_i = 24'haaaaaa;
    enable_i = 1;
    wait_cyc(600);
    // empty routing: all-zero frames
    assign_i = 24'hffffff;
    wait_cyc(300);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule